// File: doc/BRIEF.md
# Skid-Buffered Transform Stage

This block is a single pipeline register with a valid/ready handshake on both sides. Upstream offers an item with `in_vld` and `in_dat`, and the block answers with `in_rdy`. Downstream sees `out_vld` and `out_dat` and answers with `out_rdy`. Each accepted item passes through a small combinational transform before it is stored. By default the transform adds one. A parameter can select a second variant that adds two packed operands.

The output side is fully registered. A one-entry spare register catches an item that arrives while the output register is full and stalled. `in_rdy` comes straight from a flop, so the ready path never crosses the stage combinationally. Items are never lost, duplicated or reordered, and the stored items drain one per cycle once downstream is ready again. A stage is a drop-in element for valid/ready pipelines. Two of them in series give two cycles of latency and apply the transform twice.

Top module: `skid_stage`

## Requirements
- R1: While `rst` is high at a clock edge, and right after that edge, `out_vld` is low and `in_rdy` is high.
- R2: An item taken at an edge (`in_vld` and `in_rdy` high) into an empty stage makes `out_vld` high right after that edge. Before that edge `out_vld` is low.
- R3: With `XFORM = XF_INC`, `out_dat` equals the taken `in_dat` plus one, modulo 2^DATA_W. All ones gives zero.
- R4: With `XFORM = XF_ADD`, operand A is `in_dat[OP_W-1:0]` and operand B is `in_dat[2*OP_W-1:OP_W]`. `out_dat` is A+B, zero-extended. The bits above 2*OP_W are ignored.
- R5: An item leaves only at an edge where `out_vld` and `out_rdy` are both high. While `out_vld` is high and `out_rdy` is low, `out_vld` and `out_dat` keep their values.
- R6: At an edge where `in_rdy` is low, `in_vld` has no effect. No item is taken and none later appears on `out_dat`.
- R7: An item taken while the output register holds an item and `out_rdy` is low is kept in the spare register. `in_rdy` is low right after that edge and stays low until the spare register empties.
- R8: When downstream becomes ready with both registers full, the output register loads the spare item before any new input. With no new input, `out_vld` then stays high for exactly two delivery edges and then falls, and `in_rdy` returns high after the first.
- R9: With `out_rdy` held high, the stage takes and delivers one item per clock with `in_rdy` high throughout.
- R10: Under random patterns of offered items and downstream stalls, every taken item is delivered exactly once, in order, with the transform applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Upstream offers an item |
| in_dat | input | DATA_W | Upstream item (packed operands in the adder variant) |
| in_rdy | output | 1 | Stage can take an item at the next edge |
| out_vld | output | 1 | Output register holds an item |
| out_dat | output | DATA_W | Transformed item |
| out_rdy | input | 1 | Downstream takes the item at the next edge |

## Verification
The bench builds two copies of the stage. The first uses the default parameters: 32-bit data with the increment transform. It carries the directed stall, drain and throughput cases and a 10000-item random stream, and it reaches the all-ones input that wraps to zero. The second uses the adder variant with 14-bit operands. Its vector table covers both operands at their maximum, a sum that carries into bit 14, and zero operands.

// File: rtl/skid_pkg.sv
`timescale 1ns/1ps
package skid_pkg;

    // Selects the combinational transform applied to each taken item.
    typedef enum logic [0:0] {
        XF_INC = 1'b0,
        XF_ADD = 1'b1
    } xform_e;

endpackage

// File: rtl/skid_xform.sv
`timescale 1ns/1ps
module skid_xform #(
    parameter int               DATA_W = 32,
    parameter int               OP_W   = 14,
    parameter skid_pkg::xform_e XFORM  = skid_pkg::XF_INC
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);
    localparam int SUM_W = OP_W + 1;

    generate
        if (XFORM == skid_pkg::XF_ADD) begin : g_add
            logic [OP_W-1:0]  opa;
            logic [OP_W-1:0]  opb;
            logic [SUM_W-1:0] sum;
            logic             unused_hi;

            always_comb begin
                opa       = src[OP_W-1:0];
                opb       = src[2*OP_W-1:OP_W];
                sum       = {1'b0, opa} + {1'b0, opb};
                res       = DATA_W'(sum);
                unused_hi = ^src[DATA_W-1:2*OP_W];
            end
        end else begin : g_inc
            always_comb begin
                res = src + DATA_W'(1);
            end
        end
    endgenerate

endmodule

// File: rtl/skid_core.sv
`timescale 1ns/1ps
module skid_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_vld,
    input  logic [DATA_W-1:0] up_dat,
    output logic              up_rdy,
    output logic              dn_vld,
    output logic [DATA_W-1:0] dn_dat,
    input  logic              dn_rdy
);
    typedef struct packed {
        logic              out_vld;
        logic [DATA_W-1:0] out_dat;
        logic              skd_vld;
        logic [DATA_W-1:0] skd_dat;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic   take_d;
    logic   out_free_d;

    always_comb begin
        st_d       = st_q;
        take_d     = up_vld & ~st_q.skd_vld;
        out_free_d = ~st_q.out_vld | dn_rdy;

        if (out_free_d) begin
            if (st_q.skd_vld) begin
                // Drain the spare entry first to keep order.
                st_d.out_vld = 1'b1;
                st_d.out_dat = st_q.skd_dat;
                st_d.skd_vld = 1'b0;
            end else begin
                st_d.out_vld = take_d;
                if (take_d) begin
                    st_d.out_dat = up_dat;
                end
            end
        end else if (take_d) begin
            // Output is stalled: park the item in the spare register.
            st_d.skd_vld = 1'b1;
            st_d.skd_dat = up_dat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_rdy = ~st_q.skd_vld;
    assign dn_vld = st_q.out_vld;
    assign dn_dat = st_q.out_dat;

endmodule

// File: rtl/skid_stage.sv
`timescale 1ns/1ps
module skid_stage #(
    parameter int               DATA_W = 32,
    parameter int               OP_W   = 14,
    parameter skid_pkg::xform_e XFORM  = skid_pkg::XF_INC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_dat,
    output logic              in_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_dat,
    input  logic              out_rdy
);
    logic [DATA_W-1:0] xf_dat;

    skid_xform #(
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .XFORM  (XFORM)
    ) u_xform (
        .src (in_dat),
        .res (xf_dat)
    );

    skid_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .up_vld (in_vld),
        .up_dat (xf_dat),
        .up_rdy (in_rdy),
        .dn_vld (out_vld),
        .dn_dat (out_dat),
        .dn_rdy (out_rdy)
    );

endmodule

// File: rtl/skid_stage_chk.sv
`timescale 1ns/1ps
module skid_stage_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [DATA_W-1:0] in_dat,
    input logic              in_rdy,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_dat,
    input logic              out_rdy
);
    logic unused_dat;
    assign unused_dat = ^in_dat;

    assert_take_shows_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_rdy) |=> out_vld);

    assert_hold_stalled_R5: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_dat)));

    assert_blocked_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (!in_rdy && !out_rdy) |=> (!in_rdy && $stable(out_dat)));

    assert_spare_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_rdy && out_vld && !out_rdy) |=> !in_rdy);

    assert_spare_drains_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_rdy && out_vld && out_rdy) |=> (out_vld && in_rdy));

endmodule

bind skid_stage skid_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_dat  (in_dat),
    .in_rdy  (in_rdy),
    .out_vld (out_vld),
    .out_dat (out_dat),
    .out_rdy (out_rdy)
);

// File: tb/skid_stage_bench.sv
`timescale 1ns/1ps
module skid_stage_bench;
    localparam int DW    = 32;
    localparam int OW    = 14;
    localparam int NRAND = 10000;
    localparam int NVEC  = 8;

    // {operand A, operand B, expected sum}, 16 bits each (R4)
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd0,     16'd0,     16'd0},
        {16'd1,     16'd1,     16'd2},
        {16'd16383, 16'd16383, 16'd32766},
        {16'd16383, 16'd1,     16'd16384},
        {16'd8192,  16'd8192,  16'd16384},
        {16'd100,   16'd200,   16'd300},
        {16'd0,     16'd16383, 16'd16383},
        {16'd9999,  16'd3,     16'd10002}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          i_vld, i_rdy, o_vld, o_rdy;
    logic [DW-1:0] i_dat, o_dat;
    logic          a_vld, a_rdy, ao_vld, ao_rdy;
    logic [DW-1:0] a_dat, ao_dat;

    skid_stage #(.DATA_W(DW), .OP_W(OW), .XFORM(skid_pkg::XF_INC)) u_skid_stage (
        .clk(clk), .rst(rst), .in_vld(i_vld), .in_dat(i_dat), .in_rdy(i_rdy),
        .out_vld(o_vld), .out_dat(o_dat), .out_rdy(o_rdy)
    );

    skid_stage #(.DATA_W(DW), .OP_W(OW), .XFORM(skid_pkg::XF_ADD)) u_skid_stage_add (
        .clk(clk), .rst(rst), .in_vld(a_vld), .in_dat(a_dat), .in_rdy(a_rdy),
        .out_vld(ao_vld), .out_dat(ao_dat), .out_rdy(ao_rdy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        i_vld = 0; i_dat = '0; o_rdy = 0;
        a_vld = 0; a_dat = '0; ao_rdy = 1;
        repeat (3) step;
        chk("R1", 32'(o_vld), 0);
        chk("R1", 32'(i_rdy), 1);
        chk("R1", 32'(ao_vld), 0);
        chk("R1", 32'(a_rdy), 1);
        rst = 0;
        step;
        chk("R1", 32'(o_vld), 0);

        // Adder variant table walk (R4)
        for (int k = 0; k < NVEC; k++) begin
            a_vld = 1;
            a_dat = {4'hF, VEC[k][29:16], VEC[k][45:32]};
            step;
            a_vld = 0;
            chk("R4", 32'(ao_vld), 1);
            chk("R4", ao_dat, 32'(VEC[k][15:0]));
        end
        step;
        chk("R5", 32'(ao_vld), 0);

        // Latency and increment (R2, R3)
        o_rdy = 1; i_vld = 1; i_dat = 5;
        #1 chk("R2", 32'(o_vld), 0);
        step;
        i_vld = 0;
        chk("R2", 32'(o_vld), 1);
        chk("R3", o_dat, 6);
        step;
        chk("R5", 32'(o_vld), 0);

        // Wraparound (R3)
        i_vld = 1; i_dat = 32'hFFFF_FFFF;
        step;
        i_vld = 0;
        chk("R3", o_dat, 0);
        step;

        // Stall, spare fill, ignored input, drain (R5..R8)
        o_rdy = 0; i_vld = 1; i_dat = 10;
        step;
        chk("R2", 32'(o_vld), 1);
        chk("R7", 32'(i_rdy), 1);
        i_dat = 20;
        step;
        chk("R5", o_dat, 11);
        chk("R7", 32'(i_rdy), 0);
        i_dat = 30;
        step;
        chk("R6", 32'(i_rdy), 0);
        chk("R5", o_dat, 11);
        i_vld = 0; o_rdy = 1;
        #1 chk("R8", 32'(o_vld), 1);
        step;
        chk("R8", o_dat, 21);
        chk("R8", 32'(o_vld), 1);
        chk("R8", 32'(i_rdy), 1);
        step;
        chk("R6", 32'(o_vld), 0);

        // Full throughput (R9)
        for (int k = 0; k < 5; k++) begin
            i_vld = 1; i_dat = 100 + k;
            step;
            chk("R9", o_dat, 32'(101 + k));
            chk("R9", 32'(i_rdy), 1);
        end
        i_vld = 0;
        step;

        // Random stream (R10)
        begin
            int sent = 0;
            int got  = 0;
            while (got < NRAND) begin
                o_rdy = ($urandom_range(3, 0) != 0);
                if (i_rdy && sent < NRAND && $urandom_range(3, 0) != 0) begin
                    i_vld = 1;
                    i_dat = 32'(sent + 1);
                    sent++;
                end else begin
                    i_vld = 0;
                end
                if (o_vld && o_rdy) begin
                    chk("R10", o_dat, 32'(got + 2));
                    got++;
                end
                step;
            end
            i_vld = 0;
            chk("R10", 32'(sent), 32'(NRAND));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule